// File: doc/BRIEF.md
# Full-Adder Reduction Delay Bound Checker

This block tests whether a set of bits, each arriving at a known integer delay, could be reduced by a tree of full adders to k result bits by a target delay t. Each arrival delay d carries a weight S(d). S is the largest number of time-zero bits that full adders can fold into a single bit by time d. It obeys S(0) = S(1) = 1 and S(d) = S(d-1) + 2·S(d-2), which is the closed form (2^(d+1) + (-1)^d)/3. The block adds up the weights of the whole input vector. If that total exceeds k·S(t), no full-adder circuit can meet the target, and the block reports the case as infeasible. The test is a lower bound only. A feasible answer does not show that a circuit exists.

A run begins with a start pulse, which captures t and k. Input delays then arrive one per cycle, qualified by a valid strobe, and the final one is marked with last. The S values come from a table that is built when the design is elaborated. Two copies of the table are used: one indexes the incoming delay and one indexes the target. The totals are held in 40-bit accumulators. A sticky flag marks a wrap of the weight accumulator, and another sticky flag marks an input delay that falls outside the table.

Top module: `fdb_bound_check`

## Requirements
- R1: The weight of a single input of delay d equals (2^(d+1) + (-1)^d)/3 for every d from 0 to 31. In particular S(0) = S(1) = 1 and S(d) = S(d-1) + 2·S(d-2).
- R2: weight_o equals the sum of S(d) over every input accepted in the current run. An input is accepted when in_valid_i is high, a run is open and start_i is low.
- R3: cap_o equals k·S(t), using the t_i and k_i captured on the start pulse. It is visible from the cycle after start_i.
- R4: infeasible_o is 1 exactly when done_o is 1 and either weight_o > cap_o or ovf_o is 1. A weight equal to the capacity is feasible.
- R5: done_o rises in the first cycle after the input that carries in_last_i is accepted. From then until the next start_i, done_o, weight_o and infeasible_o hold, and in_valid_i has no effect.
- R6: The weight accumulator is 40 bits wide and wraps modulo 2^40. A carry out of the accumulator sets ovf_o, which stays set until the next start_i.
- R7: An accepted input with a delay above 31 is not added to the weight. It sets proto_err_o, which stays set until the next start_i. It still ends the run if in_last_i is set.
- R8: start_i clears weight_o, done_o, ovf_o and proto_err_o in the following cycle and opens a new run. Input valid in the same cycle as start_i is ignored.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a run; captures t_i and k_i |
| t_i | input | 5 | Target delay |
| k_i | input | 8 | Number of result bits allowed |
| in_valid_i | input | 1 | Input delay strobe |
| in_last_i | input | 1 | Marks the final input of the vector |
| in_delay_i | input | 6 | Arrival delay of one input bit |
| weight_o | output | 40 | Accumulated weight of the vector |
| cap_o | output | 40 | Capacity k·S(t) |
| done_o | output | 1 | Result valid and held |
| infeasible_o | output | 1 | Target cannot be met |
| ovf_o | output | 1 | Sticky weight accumulator overflow |
| proto_err_o | output | 1 | Sticky out-of-range delay seen |

## Verification
Several properties are checked on every cycle. The held result cannot move until a new start, the error flags are sticky, a start clears the state, an out-of-range delay always raises its flag, and the infeasible flag never appears without done. The bench scenarios show the rest. These include the match between the table and the closed form at every delay from 0 to 31, the exact sums for mixed vectors, and the comparison at and just past weight == capacity. They also cover the wrap after 769 inputs of delay 31, and the one-cycle latency from the last input to the result.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
  // S(d) by the recurrence S(d) = S(d-1) + 2 S(d-2), S(0)=S(1)=1
  function automatic logic [63:0] s_of(input int unsigned d);
    logic [63:0] a, b, c;
    a = 64'd1;
    b = 64'd1;
    for (int unsigned i = 2; i <= d; i++) begin
      c = b + (a << 1);
      a = b;
      b = c;
    end
    return (d == 0) ? a : b;
  endfunction
endpackage

// File: rtl/fdb_weight_lut.sv
module fdb_weight_lut #(
  parameter int MAX_DELAY = 31,
  parameter int DLY_W     = 6,
  parameter int S_W       = 32
) (
  input  logic [DLY_W-1:0] delay_i,
  output logic [S_W-1:0]   weight_o,
  output logic             oor_o
);
  localparam int NUM_D = MAX_DELAY + 1;
  localparam int IDX_W = $clog2(NUM_D);
  localparam logic [DLY_W-1:0] MAX_D_V = DLY_W'(MAX_DELAY);

  logic [S_W-1:0] tab [NUM_D];

  for (genvar g = 0; g < NUM_D; g++) begin : g_tab
    assign tab[g] = S_W'(fdb_pkg::s_of(g));
  end

  assign oor_o    = delay_i > MAX_D_V;
  assign weight_o = oor_o ? '0 : tab[delay_i[IDX_W-1:0]];
endmodule

// File: rtl/fdb_accum.sv
module fdb_accum #(
  parameter int ACC_W = 40,
  parameter int S_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [S_W-1:0]   add_val_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             ovf_o
);
  logic [ACC_W:0] nxt;
  assign nxt = {1'b0, sum_o} + {1'b0, ACC_W'(add_val_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      sum_o <= '0;
      ovf_o <= 1'b0;
    end else if (add_en_i) begin
      sum_o <= nxt[ACC_W-1:0];
      ovf_o <= ovf_o | nxt[ACC_W];
    end
  end

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_i |=> ovf_o);
endmodule

// File: rtl/fdb_bound_check.sv
module fdb_bound_check #(
  parameter int MAX_DELAY = 31,
  parameter int T_W       = 5,
  parameter int K_W       = 8,
  parameter int DLY_W     = 6,
  parameter int ACC_W     = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [T_W-1:0]   t_i,
  input  logic [K_W-1:0]   k_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  input  logic [DLY_W-1:0] in_delay_i,
  output logic [ACC_W-1:0] weight_o,
  output logic [ACC_W-1:0] cap_o,
  output logic             done_o,
  output logic             infeasible_o,
  output logic             ovf_o,
  output logic             proto_err_o
);
  localparam int S_W    = MAX_DELAY + 1;
  localparam int PROD_W = K_W + S_W;

  logic [S_W-1:0] s_in, s_t;
  logic           in_oor, t_oor;
  logic           run_q, accept, add_en;
  logic [PROD_W-1:0] prod;

  fdb_weight_lut #(.MAX_DELAY(MAX_DELAY), .DLY_W(DLY_W), .S_W(S_W)) u_lut_in (
    .delay_i(in_delay_i), .weight_o(s_in), .oor_o(in_oor));

  fdb_weight_lut #(.MAX_DELAY(MAX_DELAY), .DLY_W(DLY_W), .S_W(S_W)) u_lut_t (
    .delay_i(DLY_W'(t_i)), .weight_o(s_t), .oor_o(t_oor));

  assign accept = run_q & in_valid_i & ~start_i;
  assign add_en = accept & ~in_oor;
  assign prod   = PROD_W'(k_i) * PROD_W'(s_t);

  fdb_accum #(.ACC_W(ACC_W), .S_W(S_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i), .add_en_i(add_en),
    .add_val_i(s_in), .sum_o(weight_o), .ovf_o(ovf_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      done_o      <= 1'b0;
      proto_err_o <= 1'b0;
      cap_o       <= '0;
    end else if (start_i) begin
      run_q       <= 1'b1;
      done_o      <= 1'b0;
      proto_err_o <= 1'b0;
      cap_o       <= t_oor ? '0 : ACC_W'(prod);
    end else if (accept) begin
      proto_err_o <= proto_err_o | in_oor;
      if (in_last_i) begin
        run_q  <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  assign infeasible_o = done_o & (ovf_o | (weight_o > cap_o));

  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(weight_o) && $stable(infeasible_o));
  assert_infeas_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    infeasible_o |-> done_o);
  assert_perr_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && in_valid_i && !start_i && (in_delay_i > DLY_W'(MAX_DELAY)) |=> proto_err_o);
  assert_perr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o && !start_i |=> proto_err_o);
  assert_start_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o && !ovf_o && !proto_err_o && (weight_o == '0));
endmodule

// File: tb/sim_fdb_bound_check.sv
module sim_fdb_bound_check;
  logic clk = 0, rst_n = 0;
  logic start = 0, in_valid = 0, in_last = 0;
  logic [4:0] t = 0;
  logic [7:0] k = 0;
  logic [5:0] dly = 0;
  logic [39:0] weight, cap;
  logic done, infeas, ovf, perr;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  fdb_bound_check u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .t_i(t), .k_i(k),
    .in_valid_i(in_valid), .in_last_i(in_last), .in_delay_i(dly),
    .weight_o(weight), .cap_o(cap), .done_o(done), .infeasible_o(infeas),
    .ovf_o(ovf), .proto_err_o(perr));

  function automatic longint s_cf(int d);
    return ((64'sd1 <<< (d + 1)) + ((d % 2) ? -64'sd1 : 64'sd1)) / 3;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(int tt, int kk);
    @(negedge clk); start = 1; t = 5'(tt); k = 8'(kk);
    @(negedge clk); start = 0;
  endtask

  task automatic send(int d, bit last);
    @(negedge clk); in_valid = 1; dly = 6'(d); in_last = last;
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  task automatic t_reset;
    check(!done && !infeas && !ovf && !perr && weight == 0 && cap == 0, "R9 reset",
          longint'(weight), 0);
  endtask

  task automatic t_table;
    longint a = 1, b = 1, c;
    for (int d = 0; d <= 31; d++) begin
      longint rec;
      if (d < 2) rec = 1;
      else begin c = b + 2 * a; a = b; b = c; rec = c; end
      do_start(31, 1);
      send(d, 1);
      check(weight == 40'(s_cf(d)) && rec == s_cf(d), "R1 S(d)", longint'(weight), s_cf(d));
    end
  endtask

  task automatic t_cap;
    do_start(4, 3);
    check(cap == 40'(3 * s_cf(4)), "R3 cap t4 k3", longint'(cap), 3 * s_cf(4));
    do_start(31, 255);
    check(cap == 40'(255 * s_cf(31)), "R3 cap t31 k255", longint'(cap), 255 * s_cf(31));
  endtask

  task automatic t_mixed;
    int v[6] = '{3, 0, 2, 2, 5, 1};
    longint e = 0;
    do_start(4, 3);
    for (int i = 0; i < 6; i++) begin
      send(v[i], i == 5);
      e += s_cf(v[i]);
      if (i < 5) check(!done, "R5 no early done", done, 0);
    end
    check(weight == 40'(e), "R2 mixed sum", longint'(weight), e);
    check(done && infeas == (e > 3 * s_cf(4)), "R4 infeasible mixed", infeas, 1);
  endtask

  task automatic t_boundary;
    int v[6] = '{2, 2, 1, 1, 0, 0};
    do_start(3, 2);
    for (int i = 0; i < 6; i++) send(v[i], i == 5);
    check(weight == 40'd10 && cap == 40'd10, "R2 boundary sum", longint'(weight), 10);
    check(done && !infeas, "R4 equal is feasible", infeas, 0);
    do_start(3, 2);
    for (int i = 0; i < 6; i++) send(v[i], 0);
    send(0, 1);
    check(done && infeas, "R4 one past capacity", infeas, 1);
    send(31, 1);
    send(31, 0);
    check(done && infeas && weight == 40'd11, "R5 held after done", longint'(weight), 11);
  endtask

  task automatic t_overflow;
    longint e = (769 * s_cf(31)) & ((64'sd1 <<< 40) - 1);
    do_start(31, 255);
    for (int i = 0; i < 768; i++) send(31, 0);
    check(!ovf, "R6 no wrap at 768", ovf, 0);
    send(31, 1);
    check(ovf && weight == 40'(e), "R6 wrap value", longint'(weight), e);
    check(infeas, "R4 overflow infeasible", infeas, 1);
    do_start(2, 1);
    check(!ovf && !done && weight == 0, "R8 start clears", ovf, 0);
  endtask

  task automatic t_proto;
    do_start(5, 1);
    send(2, 0);
    send(40, 0);
    check(perr && weight == 40'(s_cf(2)), "R7 oor ignored", longint'(weight), s_cf(2));
    send(1, 1);
    check(perr && done && weight == 40'(s_cf(2) + 1), "R7 sticky", longint'(weight), s_cf(2) + 1);
    @(negedge clk); start = 1; t = 5; k = 1; in_valid = 1; dly = 4; in_last = 1;
    @(negedge clk); start = 0; in_valid = 0; in_last = 0;
    check(!perr && !done && weight == 0, "R8 start cycle input ignored", longint'(weight), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_table();
    t_cap();
    t_mixed();
    t_boundary();
    t_overflow();
    t_proto();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule